// File: doc/BRIEF.md
# Serial Port Interrupt Request Generator

This block raises the two interrupt requests of a simple serial port: one when the receive holding buffer holds a fresh character, one when the transmit holding buffer can accept a new character. It keeps the transmit-empty and receive-full flags itself. Register-side strobes from the processor clear these flags. Single-cycle pulses from the shift-register side set them.

A one-word enable register carries one enable bit for each direction. Each request is a level. It stays asserted while its flag and its enable are both 1. It drops only when software clears the enable or performs the buffer access that clears the flag. Beside each request, the block presents the constant program-memory address of that request's two-byte vector.

Top module: `usart_irq_ctrl`

## Requirements
- R1: After reset both requests are low, the transmit-empty flag is 1, the receive-full flag is 0 and both enables are 0; reset may be applied again at any time with the same result.
- R2: A cycle with `en_wr` high loads bit 1 of `en_wdata` as the transmit enable and bit 0 as the receive enable; all other data bits are ignored, and the enables hold while `en_wr` is low.
- R3: `tx_irq` is 1 exactly while the transmit-empty flag and the transmit enable are both 1.
- R4: A `tx_buf_wr` strobe without a simultaneous `tx_load_pulse` clears the transmit-empty flag from the next cycle on.
- R5: A `tx_load_pulse` sets the transmit-empty flag from the next cycle on.
- R6: `rx_irq` is 1 exactly while the receive-full flag and the receive enable are both 1.
- R7: An `rx_buf_rd` strobe without a simultaneous `rx_done_pulse` clears the receive-full flag from the next cycle on.
- R8: An `rx_done_pulse` sets the receive-full flag from the next cycle on.
- R9: When a buffer strobe and the hardware set pulse of the same flag coincide, the flag ends up 1.
- R10: `rx_vector` is constantly 0xEC and `tx_vector` is constantly 0xEE, so the two-byte vectors fill 0xEC to 0xEF.
- R11: Clearing an enable removes its request while the flag is kept, and setting the enable again restores the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | DATA_W | Enable register write data |
| tx_buf_wr | input | 1 | Processor writes the transmit buffer |
| rx_buf_rd | input | 1 | Processor reads the receive buffer |
| tx_load_pulse | input | 1 | Transmitter moved the buffer into its shift register |
| rx_done_pulse | input | 1 | Receiver completed a character into the buffer |
| tx_irq | output | 1 | Transmit request level |
| tx_vector | output | 8 | Transmit vector address |
| rx_irq | output | 1 | Receive request level |
| rx_vector | output | 8 | Receive vector address |

## Verification
The bench builds the block with its default parameters. These are an 8-bit enable data word, the transmit enable at bit 1, the receive enable at bit 0 and a vector base of 0xEC. Because the word is 8 bits wide, writes with every unused data bit set can be shown to leave both requests untouched. The vector outputs can also be compared with the fixed addresses 0xEC and 0xEE. The stimulus table covers each flag under set alone, clear alone, both together and neither. It also covers each enable being dropped and raised again while its flag holds, and a reset applied in the middle of a run.

// File: rtl/usart_irq_pkg.sv
package usart_irq_pkg;

    localparam int NUM_CH    = 2;
    localparam int VEC_BYTES = 2;

    typedef enum logic {
        CH_RX = 1'b0,
        CH_TX = 1'b1
    } chan_e;

    function automatic logic [7:0] vec_addr(input logic [7:0] base, input int ch);
        return 8'(int'(base) + ch * VEC_BYTES);
    endfunction

endpackage

// File: rtl/usart_irq_flag.sv
module usart_irq_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) state_d.flag = 1'b0;
        if (set_i) state_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q.flag <= RST_VAL;
        else        state_q      <= state_d;
    end

    assign flag_o = state_q.flag;

    // R5 R8 R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R4 R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));

endmodule

// File: rtl/usart_irq_enable.sv
module usart_irq_enable #(
    parameter int DATA_W    = 8,
    parameter int TX_EN_BIT = 1,
    parameter int RX_EN_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              tx_en_o,
    output logic              rx_en_o
);

    typedef struct packed {
        logic tx_en;
        logic rx_en;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.tx_en = wdata_i[TX_EN_BIT];
            state_d.rx_en = wdata_i[RX_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tx_en_o = state_q.tx_en;
    assign rx_en_o = state_q.rx_en;

    // R2
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (tx_en_o == $past(wdata_i[TX_EN_BIT])) && (rx_en_o == $past(wdata_i[RX_EN_BIT])));

    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(tx_en_o) && $stable(rx_en_o));

endmodule

// File: rtl/usart_irq_req.sv
module usart_irq_req (
    input  logic flag_i,
    input  logic en_i,
    output logic req_o
);

    assign req_o = flag_i & en_i;

endmodule

// File: rtl/usart_irq_ctrl.sv
module usart_irq_ctrl #(
    parameter int         DATA_W    = 8,
    parameter int         TX_EN_BIT = 1,
    parameter int         RX_EN_BIT = 0,
    parameter logic [7:0] VEC_BASE  = 8'hEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] en_wdata,
    input  logic              tx_buf_wr,
    input  logic              rx_buf_rd,
    input  logic              tx_load_pulse,
    input  logic              rx_done_pulse,
    output logic              tx_irq,
    output logic [7:0]        tx_vector,
    output logic              rx_irq,
    output logic [7:0]        rx_vector
);

    import usart_irq_pkg::*;

    logic [NUM_CH-1:0] set_v, clr_v, flag_v, en_v, req_v;

    assign set_v[CH_RX] = rx_done_pulse;
    assign clr_v[CH_RX] = rx_buf_rd;
    assign set_v[CH_TX] = tx_load_pulse;
    assign clr_v[CH_TX] = tx_buf_wr;

    usart_irq_enable #(
        .DATA_W    (DATA_W),
        .TX_EN_BIT (TX_EN_BIT),
        .RX_EN_BIT (RX_EN_BIT)
    ) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (en_wdata),
        .tx_en_o (en_v[CH_TX]),
        .rx_en_o (en_v[CH_RX])
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        usart_irq_flag #(
            .RST_VAL (ch == int'(CH_TX))
        ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[ch]),
            .clr_i  (clr_v[ch]),
            .flag_o (flag_v[ch])
        );

        usart_irq_req u_req (
            .flag_i (flag_v[ch]),
            .en_i   (en_v[ch]),
            .req_o  (req_v[ch])
        );
    end

    assign tx_irq    = req_v[CH_TX];
    assign rx_irq    = req_v[CH_RX];
    assign tx_vector = vec_addr(VEC_BASE, int'(CH_TX));
    assign rx_vector = vec_addr(VEC_BASE, int'(CH_RX));

    // R4
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_buf_wr && !tx_load_pulse) |=> !tx_irq);

    // R7
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_buf_rd && !rx_done_pulse) |=> !rx_irq);

    // R11
    tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_wdata[TX_EN_BIT]) |=> !tx_irq);

    // R11
    rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_wdata[RX_EN_BIT]) |=> !rx_irq);

endmodule

// File: tb/test_usart_irq_ctrl.sv
module test_usart_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en_wr, tx_buf_wr, rx_buf_rd, tx_load_pulse, rx_done_pulse;
    logic [7:0] en_wdata;
    logic       tx_irq, rx_irq;
    logic [7:0] tx_vector, rx_vector;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    usart_irq_ctrl i_usart_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_wr         (en_wr),
        .en_wdata      (en_wdata),
        .tx_buf_wr     (tx_buf_wr),
        .rx_buf_rd     (rx_buf_rd),
        .tx_load_pulse (tx_load_pulse),
        .rx_done_pulse (rx_done_pulse),
        .tx_irq        (tx_irq),
        .tx_vector     (tx_vector),
        .rx_irq        (rx_irq),
        .rx_vector     (rx_vector)
    );

    // Row: [16] en_wr, [15:8] en_wdata, [7] tx_buf_wr, [6] rx_buf_rd,
    //      [5] tx_load_pulse, [4] rx_done_pulse, [1] expected tx_irq, [0] expected rx_irq
    localparam int NV = 16;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h00, 4'b0000, 4'b0000},  // R1 idle after reset
        {1'b1, 8'h02, 4'b0000, 4'b0010},  // R2 R3 tx enable only
        {1'b0, 8'h00, 4'b1000, 4'b0000},  // R4 buffer write
        {1'b0, 8'h00, 4'b0010, 4'b0010},  // R5 load pulse
        {1'b1, 8'h01, 4'b0000, 4'b0000},  // R11 R6 swap enables, rx not full
        {1'b0, 8'h00, 4'b0001, 4'b0001},  // R8 receive done
        {1'b1, 8'h00, 4'b0000, 4'b0000},  // R11 rx enable off
        {1'b1, 8'h01, 4'b0000, 4'b0001},  // R11 rx enable back on
        {1'b0, 8'h00, 4'b0100, 4'b0000},  // R7 buffer read
        {1'b0, 8'h00, 4'b0101, 4'b0001},  // R9 read with done
        {1'b1, 8'hFC, 4'b0000, 4'b0000},  // R2 unused bits ignored
        {1'b1, 8'h03, 4'b0000, 4'b0011},  // R3 R6 both enabled
        {1'b0, 8'h00, 4'b1010, 4'b0011},  // R9 write with load
        {1'b0, 8'h00, 4'b1100, 4'b0000},  // R4 R7 both cleared
        {1'b0, 8'h00, 4'b0000, 4'b0000},  // R2 enables hold
        {1'b0, 8'h00, 4'b0011, 4'b0011}   // R5 R8 both set
    };
    localparam int TAG [NV] = '{1, 3, 4, 5, 11, 8, 11, 11, 7, 9, 2, 6, 9, 4, 2, 5};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        en_wr = 1'b0; en_wdata = '0; tx_buf_wr = 1'b0; rx_buf_rd = 1'b0;
        tx_load_pulse = 1'b0; rx_done_pulse = 1'b0;
    endtask

    task automatic apply(input logic [16:0] v);
        @(negedge clk);
        en_wr = v[16]; en_wdata = v[15:8]; tx_buf_wr = v[7]; rx_buf_rd = v[6];
        tx_load_pulse = v[5]; rx_done_pulse = v[4];
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        do_reset();
        // R1
        check("R1 tx_irq", {7'd0, tx_irq}, 8'd0);
        check("R1 rx_irq", {7'd0, rx_irq}, 8'd0);
        // R10
        check("R10 rx_vector", rx_vector, 8'hEC);
        check("R10 tx_vector", tx_vector, 8'hEE);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R%0d row %0d tx_irq", TAG[i], i), {7'd0, tx_irq}, {7'd0, VEC[i][1]});
            check($sformatf("R%0d row %0d rx_irq", TAG[i], i), {7'd0, rx_irq}, {7'd0, VEC[i][0]});
        end

        // R1: reset in mid-run restores the flags and clears the enables
        do_reset();
        check("R1 tx_irq after rerun reset", {7'd0, tx_irq}, 8'd0);
        check("R1 rx_irq after rerun reset", {7'd0, rx_irq}, 8'd0);
        apply({1'b1, 8'h03, 4'b0000, 4'b0000});
        check("R1 tx empty after reset", {7'd0, tx_irq}, 8'd1);
        check("R1 rx not full after reset", {7'd0, rx_irq}, 8'd0);

        // R10 vectors unaffected by activity
        check("R10 rx_vector late", rx_vector, 8'hEC);
        check("R10 tx_vector late", tx_vector, 8'hEE);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule